// File: doc/BRIEF.md
# Flash Command Register Sequencer

This block is the software-facing front end of a small embedded flash array. Software loads a start address, an end address and a four-word write buffer, then writes an 8-bit control register. That register holds a command code, a start bit and a forced-stop bit. When the start bit is written together with a legal code, the sequencer runs the command against an internal word array, one step at a time, with fixed step latencies. The ready flag is low while the command runs.

The block has four operations:
- Program stores the buffer at consecutive words.
- Blank check scans an inclusive address range for non-erased words.
- Block erase clears every block touched by a range.
- All-block erase clears the whole array faster than erasing it block by block.

An illegal command sets an error flag and does nothing else. A soft-reset bit and a program/erase mode input control when the control register may be written or cleared.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the control register reads 00h. Bits 5 and 4 of the control register always read 0, whatever value is written to them. The control register layout is: bits 3..0 command code, bit 6 forced stop, bit 7 start.
- R2: Writing the control register with bit 7 set and a legal code starts the command, and ready reads 0 from the next clock. The legal codes are 1h program, 3h blank check, 4h block erase and 6h all-block erase.
- R3: Writing the control register with bit 7 set and any other code (including 0h) sets err, leaves ready at 1 and leaves the array unchanged. Writing 00h is legal and clears err.
- R4: Program writes buffer words 0..3 to start address +0..+3. It takes 4 cycles per word, so ready stays low for 16 cycles.
- R5: Blank check examines every word from the start address through the end address, one cycle per word. It sets blank_dirty if any examined word differs from FFFFh. If the end address is below the start address, only the start word is examined.
- R6: Block erase sets to FFFFh every 16-word block from the block holding the start address through the block holding the end address. It takes 32 cycles per block. Words outside those blocks are kept.
- R7: All-block erase sets all 256 words to FFFFh in 64 cycles.
- R8: While a command runs, a control write with bit 6 set, or with bit 7 clear, aborts it. Ready is 1 after that clock, and no later step of the command is performed.
- R9: While pe_mode is 0, control register writes are ignored.
- R10: While the soft-reset bit (register select 1, data bit 0) is 1:
  - control writes are ignored;
  - the control register is cleared to 00h whenever no command is running;
  - the control register is left untouched while a command is running.
- R11: After reset, ready is 1, err is 0, blank_dirty is 0 and every array word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_mode | input | 1 | Program/erase mode; control writes are accepted only when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 soft reset, 2 start address, 3 end address, 4..7 buffer words 0..3 |
| wr_data | input | 16 | Register write data |
| ctrl_rdata | output | 8 | Control register readback |
| arr_raddr | input | 8 | Array read address |
| arr_rdata | output | 16 | Array read data (combinational) |
| ready | output | 1 | 1 when no command is running |
| err | output | 1 | Illegal command flag |
| blank_dirty | output | 1 | Blank check found a programmed word |

## Verification
The hardest situation to reach is an abort or a soft reset that lands in the middle of a multi-block erase. It has to arrive after the command has started and before the block holding the test data reaches its erase cycle. The bench first programs a marker word in the last block of a four-block range. It then starts the erase and counts clocks from the start write, so that the stop request, or the soft-reset write, arrives well inside the first block's 32-cycle window. Finally it reads the marker and the control register back through the ports.

// File: rtl/flash_seq_pkg.sv
// Package: shared encodings for the flash command sequencer.
// Assumes: register select and command codes are fixed by software convention.
package flash_seq_pkg;
    localparam logic [3:0] CMD_PROG   = 4'h1;
    localparam logic [3:0] CMD_BLANK  = 4'h3;
    localparam logic [3:0] CMD_BERASE = 4'h4;
    localparam logic [3:0] CMD_AERASE = 4'h6;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_SRST  = 3'd1;
    localparam logic [2:0] SEL_SADDR = 3'd2;
    localparam logic [2:0] SEL_EADDR = 3'd3;
    localparam logic [2:0] SEL_WB0   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_BLANK, ST_BERASE, ST_AERASE
    } seq_state_e;

    // Returns 1 for the four command codes that may be started.
    function automatic logic cmd_legal(input logic [3:0] c);
        return (c == CMD_PROG) || (c == CMD_BLANK) ||
               (c == CMD_BERASE) || (c == CMD_AERASE);
    endfunction
endpackage

// File: rtl/flash_ctrl_regs.sv
// Module: software register file and access rules for the sequencer.
// Owns the control register, soft-reset bit, address registers and the
// write buffer. Decodes start, abort and illegal-command events.
// Assumes: one register write per cycle; busy comes from the sequencer.
module flash_ctrl_regs
    import flash_seq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int WB_WORDS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pe_mode,
    input  logic                   wr_en,
    input  logic [2:0]             wr_sel,
    input  logic [DW-1:0]          wr_data,
    input  logic                   busy,
    output logic [7:0]             ctrl_q,
    output logic [AW-1:0]          saddr,
    output logic [AW-1:0]          eaddr,
    output logic [WB_WORDS*DW-1:0] wbuf,
    output logic                   start,
    output logic [3:0]             cmd,
    output logic                   abort,
    output logic                   err_q
);
    logic       srst_q;
    logic       ctrl_wr;
    logic       illegal;
    logic [7:0] wval;

    // Decode a control write, forcing the reserved bits to zero.
    always_comb begin
        ctrl_wr = wr_en && (wr_sel == SEL_CTRL) && pe_mode && !srst_q;
        wval    = {wr_data[7:6], 2'b00, wr_data[3:0]};
        cmd     = wval[3:0];
        start   = ctrl_wr && !busy && wval[7] && cmd_legal(wval[3:0]);
        illegal = ctrl_wr && !busy && wval[7] && !cmd_legal(wval[3:0]);
        abort   = ctrl_wr && busy && (wval[6] || !wval[7]);
    end

    // Control register: software write, or soft-reset clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (ctrl_wr)          ctrl_q <= wval;
        else if (srst_q && !busy)  ctrl_q <= '0;
    end

    // Soft-reset bit, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                               srst_q <= 1'b0;
        else if (wr_en && wr_sel == SEL_SRST)     srst_q <= wr_data[0];
    end

    // Error flag: set by an illegal start, cleared by a legal start, 00h or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               err_q <= 1'b0;
        else if (illegal)                         err_q <= 1'b1;
        else if (start || (ctrl_wr && wval == 8'h00) || (srst_q && !busy))
                                                  err_q <= 1'b0;
    end

    // Address registers, held while a command runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saddr <= '0;
            eaddr <= '0;
        end else if (wr_en && !busy) begin
            if (wr_sel == SEL_SADDR) saddr <= wr_data[AW-1:0];
            if (wr_sel == SEL_EADDR) eaddr <= wr_data[AW-1:0];
        end
    end

    for (genvar g = 0; g < WB_WORDS; g++) begin : g_wbuf
        // Write-buffer word g, held while a command runs.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wbuf[g*DW +: DW] <= '0;
            else if (wr_en && !busy && wr_sel == SEL_WB0 + 3'(g))
                wbuf[g*DW +: DW] <= wr_data;
        end
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[5:4] == 2'b00);
    p_illegal_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> err_q);
    p_pe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_mode && !srst_q) |=> $stable(ctrl_q));
    p_srst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !busy) |=> ctrl_q == 8'h00);
    p_srst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && busy) |=> $stable(ctrl_q));
endmodule

// File: rtl/flash_word_array.sv
// Module: behavioural word array standing in for the flash cells.
// Supports a word write, a whole-block erase and an all-block erase in a
// single cycle, plus two combinational read ports.
// Assumes: the sequencer never asserts two modify requests at once.
module flash_word_array #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic             blk_erase,
    input  logic [AW-BLK_W-1:0] blk_idx,
    input  logic             all_erase,
    input  logic [AW-1:0]    raddr_a,
    output logic [DW-1:0]    rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [DW-1:0]    rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Apply erase or write to every word; reset leaves the array erased.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (all_erase || (blk_erase && (AW'(i) >> BLK_W) == AW'(blk_idx)))
                mem[i] <= '1;
            else if (we && waddr == AW'(i))
                mem[i] <= wdata;
        end
    end

    // Combinational read ports.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end

    p_all_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        all_erase |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/flash_seq_fsm.sv
// Module: command sequencer. Walks program words, blank-check addresses
// and erase blocks with fixed per-step latencies, and drives the array.
// Assumes: start and abort are single-cycle events from the register file.
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int BLK_W      = 4,
    parameter int WB_WORDS   = 4,
    parameter int PROG_CYC   = 4,
    parameter int BERASE_CYC = 32,
    parameter int AERASE_CYC = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [3:0]             cmd,
    input  logic                   abort,
    input  logic [AW-1:0]          saddr,
    input  logic [AW-1:0]          eaddr,
    input  logic [WB_WORDS*DW-1:0] wbuf,
    input  logic [DW-1:0]          rd_data,
    output logic [AW-1:0]          rd_addr,
    output logic                   arr_we,
    output logic [AW-1:0]          arr_waddr,
    output logic [DW-1:0]          arr_wdata,
    output logic                   blk_erase,
    output logic [AW-BLK_W-1:0]    blk_idx,
    output logic                   all_erase,
    output logic                   busy,
    output logic                   blank_dirty
);
    localparam int CNT_W  = $clog2(PROG_CYC + BERASE_CYC + AERASE_CYC) + 1;
    localparam int WIDX_W = (WB_WORDS > 1) ? $clog2(WB_WORDS) : 1;
    localparam int BW     = AW - BLK_W;

    seq_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [AW-1:0]     cur;
    logic [WIDX_W-1:0] widx;
    logic [BW-1:0]     blk_cur;
    logic [BW-1:0]     blk_end;

    // Block indices of the walking pointer and the end address.
    always_comb begin
        blk_cur = cur[AW-1:BLK_W];
        blk_end = eaddr[AW-1:BLK_W];
    end

    // Sequencer state, step counter, walk pointer and blank result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            cur         <= '0;
            widx        <= '0;
            blank_dirty <= 1'b0;
        end else if (abort && st != ST_IDLE) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    cnt  <= '0;
                    widx <= '0;
                    cur  <= saddr;
                    unique case (cmd)
                        CMD_PROG:   st <= ST_PROG;
                        CMD_BLANK: begin
                            st          <= ST_BLANK;
                            blank_dirty <= 1'b0;
                        end
                        CMD_BERASE: st <= ST_BERASE;
                        default:    st <= ST_AERASE;
                    endcase
                end
                ST_PROG: begin
                    if (cnt == CNT_W'(PROG_CYC - 1)) begin
                        cnt <= '0;
                        if (widx == WIDX_W'(WB_WORDS - 1)) st <= ST_IDLE;
                        else widx <= widx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (rd_data != '1) blank_dirty <= 1'b1;
                    if (cur >= eaddr) st <= ST_IDLE;
                    else cur <= cur + 1'b1;
                end
                ST_BERASE: begin
                    if (cnt == CNT_W'(BERASE_CYC - 1)) begin
                        cnt <= '0;
                        if (blk_cur >= blk_end) st <= ST_IDLE;
                        else cur <= {BW'(blk_cur + 1'b1), {BLK_W{1'b0}}};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_AERASE: begin
                    if (cnt == CNT_W'(AERASE_CYC - 1)) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Array requests on the last cycle of each step; an abort suppresses them.
    always_comb begin
        busy      = (st != ST_IDLE);
        rd_addr   = cur;
        arr_we    = (st == ST_PROG) && (cnt == CNT_W'(PROG_CYC - 1)) && !abort;
        arr_waddr = saddr + AW'(widx);
        arr_wdata = wbuf[widx*DW +: DW];
        blk_erase = (st == ST_BERASE) && (cnt == CNT_W'(BERASE_CYC - 1)) && !abort;
        blk_idx   = blk_cur;
        all_erase = (st == ST_AERASE) && (cnt == CNT_W'(AERASE_CYC - 1)) && !abort;
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> !busy);
    p_no_write_on_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !(arr_we || blk_erase || all_erase));
endmodule

// File: rtl/flash_cmd_seq.sv
// Module: top of the flash command sequencer. Connects the register file,
// the sequencer and the word array.
// Assumes: software polls ready before issuing the next command.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int BLK_W      = 4,
    parameter int WB_WORDS   = 4,
    parameter int PROG_CYC   = 4,
    parameter int BERASE_CYC = 32,
    parameter int AERASE_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pe_mode,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [7:0]    ctrl_rdata,
    input  logic [AW-1:0] arr_raddr,
    output logic [DW-1:0] arr_rdata,
    output logic          ready,
    output logic          err,
    output logic          blank_dirty
);
    logic                   busy, start, abort;
    logic [3:0]             cmd;
    logic [AW-1:0]          saddr, eaddr, rd_addr, arr_waddr;
    logic [WB_WORDS*DW-1:0] wbuf;
    logic [DW-1:0]          rd_data, arr_wdata;
    logic                   arr_we, blk_erase, all_erase;
    logic [AW-BLK_W-1:0]    blk_idx;

    flash_ctrl_regs #(.AW(AW), .DW(DW), .WB_WORDS(WB_WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .pe_mode(pe_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy), .ctrl_q(ctrl_rdata),
        .saddr(saddr), .eaddr(eaddr), .wbuf(wbuf), .start(start), .cmd(cmd),
        .abort(abort), .err_q(err)
    );

    flash_seq_fsm #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .WB_WORDS(WB_WORDS),
                    .PROG_CYC(PROG_CYC), .BERASE_CYC(BERASE_CYC),
                    .AERASE_CYC(AERASE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .abort(abort),
        .saddr(saddr), .eaddr(eaddr), .wbuf(wbuf), .rd_data(rd_data),
        .rd_addr(rd_addr), .arr_we(arr_we), .arr_waddr(arr_waddr),
        .arr_wdata(arr_wdata), .blk_erase(blk_erase), .blk_idx(blk_idx),
        .all_erase(all_erase), .busy(busy), .blank_dirty(blank_dirty)
    );

    flash_word_array #(.AW(AW), .DW(DW), .BLK_W(BLK_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .blk_erase(blk_erase), .blk_idx(blk_idx),
        .all_erase(all_erase), .raddr_a(rd_addr), .rdata_a(rd_data),
        .raddr_b(arr_raddr), .rdata_b(arr_rdata)
    );

    // Ready is the inverse of the sequencer's busy state.
    always_comb ready = !busy;
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  ctrl_rdata;
    logic [7:0]  arr_raddr = '0;
    logic [15:0] arr_rdata;
    logic        ready, err, blank_dirty;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .pe_mode(pe_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rdata(ctrl_rdata),
        .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .ready(ready),
        .err(err), .blank_dirty(blank_dirty)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_arr(input logic [7:0] a, output logic [15:0] d);
        arr_raddr = a;
        #1;
        d = arr_rdata;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [3:0] code, output int n);
        wr(3'd0, {8'h00, 4'h8, code});
        wait_ready(n);
        wr(3'd0, 16'h0000);
    endtask

    task automatic prog4(input logic [7:0] a, input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] w3);
        int n;
        wr(3'd2, {8'h00, a});
        wr(3'd4, w0); wr(3'd5, w1); wr(3'd6, w2); wr(3'd7, w3);
        run(4'h1, n);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R11", "ready", ready, 1);
        check("R11", "err", err, 0);
        check("R11", "blank_dirty", blank_dirty, 0);
        check("R1", "ctrl reset", ctrl_rdata, 8'h00);
        rd_arr(8'h00, d); check("R11", "arr[00]", d, 16'hFFFF);
        rd_arr(8'hFF, d); check("R11", "arr[FF]", d, 16'hFFFF);
    endtask

    task automatic t_reserved();
        wr(3'd0, 16'h003F);
        check("R1", "reserved bits", ctrl_rdata, 8'h0F);
        check("R1", "no start", ready, 1);
        wr(3'd0, 16'h0000);
        check("R1", "cleared", ctrl_rdata, 8'h00);
    endtask

    task automatic t_program();
        logic [15:0] d;
        int n;
        wr(3'd2, 16'h0020);
        wr(3'd4, 16'h1111); wr(3'd5, 16'h2222); wr(3'd6, 16'h3333); wr(3'd7, 16'h4444);
        wr(3'd0, 16'h0081);
        check("R2", "ready low after start", ready, 0);
        wait_ready(n);
        check("R4", "program cycles", n, 16);
        wr(3'd0, 16'h0000);
        rd_arr(8'h20, d); check("R4", "word0", d, 16'h1111);
        rd_arr(8'h21, d); check("R4", "word1", d, 16'h2222);
        rd_arr(8'h22, d); check("R4", "word2", d, 16'h3333);
        rd_arr(8'h23, d); check("R4", "word3", d, 16'h4444);
        rd_arr(8'h24, d); check("R4", "next word untouched", d, 16'hFFFF);
    endtask

    task automatic t_blank();
        int n;
        wr(3'd2, 16'h0020); wr(3'd3, 16'h002F);
        run(4'h3, n);
        check("R5", "dirty range cycles", n, 16);
        check("R5", "dirty range flag", blank_dirty, 1);
        wr(3'd2, 16'h0030); wr(3'd3, 16'h003F);
        run(4'h3, n);
        check("R5", "clean range cycles", n, 16);
        check("R5", "clean range flag", blank_dirty, 0);
        wr(3'd2, 16'h0023); wr(3'd3, 16'h0010);
        run(4'h3, n);
        check("R5", "end below start cycles", n, 1);
        check("R5", "end below start flag", blank_dirty, 1);
    endtask

    task automatic t_berase();
        logic [15:0] d;
        int n;
        prog4(8'h41, 16'hA1A1, 16'hA2A2, 16'hA3A3, 16'hA4A4);
        prog4(8'h50, 16'h5555, 16'h5556, 16'h5557, 16'h5558);
        prog4(8'h10, 16'h0101, 16'h0202, 16'h0303, 16'h0404);
        wr(3'd2, 16'h0025); wr(3'd3, 16'h0041);
        run(4'h4, n);
        check("R6", "three block cycles", n, 96);
        rd_arr(8'h20, d); check("R6", "block2 erased", d, 16'hFFFF);
        rd_arr(8'h41, d); check("R6", "block4 erased", d, 16'hFFFF);
        rd_arr(8'h44, d); check("R6", "block4 tail erased", d, 16'hFFFF);
        rd_arr(8'h50, d); check("R6", "block5 kept", d, 16'h5555);
        rd_arr(8'h10, d); check("R6", "block1 kept", d, 16'h0101);
    endtask

    task automatic t_aerase();
        logic [15:0] d;
        int n;
        run(4'h6, n);
        check("R7", "all erase cycles", n, 64);
        rd_arr(8'h50, d); check("R7", "arr[50]", d, 16'hFFFF);
        rd_arr(8'h10, d); check("R7", "arr[10]", d, 16'hFFFF);
    endtask

    task automatic t_illegal();
        logic [15:0] d;
        prog4(8'h60, 16'h6666, 16'h6667, 16'h6668, 16'h6669);
        wr(3'd2, 16'h0060); wr(3'd3, 16'h006F);
        wr(3'd0, 16'h0082);
        check("R3", "ready stays", ready, 1);
        check("R3", "err set", err, 1);
        repeat (80) @(negedge clk);
        rd_arr(8'h60, d); check("R3", "array unchanged", d, 16'h6666);
        wr(3'd0, 16'h0000);
        check("R3", "00h clears err", err, 0);
        wr(3'd0, 16'h0080);
        check("R3", "code 0 with start is error", err, 1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        int n;
        prog4(8'h30, 16'hC0DE, 16'hC0DF, 16'hC0E0, 16'hC0E1);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0030);
        wr(3'd0, 16'h0084);
        repeat (10) @(negedge clk);
        wr(3'd0, 16'h00C4);
        check("R8", "stop bit ready", ready, 1);
        repeat (200) @(negedge clk);
        rd_arr(8'h30, d); check("R8", "stop skips later blocks", d, 16'hC0DE);
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0084);
        repeat (5) @(negedge clk);
        wr(3'd0, 16'h0004);
        check("R8", "clear start ready", ready, 1);
        repeat (200) @(negedge clk);
        rd_arr(8'h30, d); check("R8", "clear start skips blocks", d, 16'hC0DE);
        wait_ready(n);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_pe_gate();
        pe_mode = 1'b0;
        wr(3'd0, 16'h0001);
        check("R9", "ctrl unchanged", ctrl_rdata, 8'h00);
        wr(3'd0, 16'h0081);
        check("R9", "no start", ready, 1);
        pe_mode = 1'b1;
    endtask

    task automatic t_srst();
        int n;
        wr(3'd0, 16'h0003);
        check("R10", "pre value", ctrl_rdata, 8'h03);
        wr(3'd1, 16'h0001);
        @(negedge clk);
        check("R10", "cleared when idle", ctrl_rdata, 8'h00);
        wr(3'd0, 16'h0003);
        check("R10", "write blocked", ctrl_rdata, 8'h00);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0030);
        wr(3'd0, 16'h0084);
        repeat (4) @(negedge clk);
        wr(3'd1, 16'h0001);
        repeat (3) @(negedge clk);
        check("R10", "held while busy", ctrl_rdata, 8'h84);
        check("R10", "command continues", ready, 0);
        wait_ready(n);
        @(negedge clk);
        check("R10", "cleared after command", ctrl_rdata, 8'h00);
        wr(3'd1, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_program();
        t_blank();
        t_berase();
        t_aerase();
        t_illegal();
        t_abort();
        t_pe_gate();
        t_srst();
        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule